// File: doc/BRIEF.md
# Byte-Lane Bus Parity Checker with Error Capture

This block watches outbound requests on an internal bus and checks one parity bit per byte lane. The address bus is 36 bits wide and the data bus is 128 bits wide. On the data bus, the parity of each lane also covers that lane's write byte-enable bit. A lane is correct when its parity bit, XORed with every bit the lane covers, gives zero. Data lanes are checked only when the request carries data.

When any lane fails, the block captures an error record. The record holds the request address, one error mask for the address lanes, one error mask for the data lanes, and a flag that says whether the error was an address error or a data error. The record is sticky: it holds the first failure until software writes one to clear it. A level interrupt is raised while a record is held and the interrupt is enabled.

A check-enable input turns outbound checking off. The generator for the inbound direction keeps running either way. For each lane it produces the parity bit that makes that lane's XOR zero.

Top module: `bus_parity_guard`

## Requirements
- R1: Address lanes 0 to 3 each cover address bits [8i+7:8i]. A lane is in error when its parity bit `req_addr_par[i]` XOR those eight bits is 1. Error mask bit i stands for lane i.
- R2: The top address lane, `req_addr_par[4]`, covers only address bits [35:32]. It uses the same zero-XOR rule.
- R3: Data lane i covers data bits [8i+7:8i] plus `req_be[i]`. Its parity bit is `req_data_par[i]`. Data lanes are checked only when `req_has_data` is 1.
- R4: Checks happen only in a cycle in which `req_valid` is 1. In any other cycle, bad parity leaves the log unchanged.
- R5: While `chk_en` is 0, no error is captured, whatever the parity.
- R6: The first failing request is captured at the clock edge that samples it, so it is visible in the next cycle. The capture sets `log_valid`=1 and records:
  - `log_addr`, the request address;
  - `log_addr_mask` and `log_data_mask`, the failing lanes;
  - `log_is_data`, which is 1 when no address lane failed and at least one data lane failed, and 0 when any address lane failed.
- R7: While `log_valid` is 1 and no clear is applied, later errors do not change any log field.
- R8: `log_clear`=1 at a clock edge clears `log_valid`. If a failing request is sampled at that same edge, its record is captured instead.
- R9: `irq` is 1 exactly while `log_valid` is 1 and `irq_en` is 1.
- R10: The generator outputs work whatever the value of `chk_en`:
  - `gen_addr_par[i]` is the XOR of the bits that address lane i covers;
  - `gen_data_par[i]` is the XOR of data byte i and `gen_be[i]`.
- R11: After reset, `log_valid`, `irq`, both masks, `log_addr` and `log_is_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Outbound parity checking enable |
| irq_en | input | 1 | Interrupt enable |
| req_valid | input | 1 | Outbound request strobe |
| req_addr | input | 36 | Request address |
| req_addr_par | input | 5 | Address lane parity bits |
| req_has_data | input | 1 | Request carries data |
| req_data | input | 128 | Request data |
| req_be | input | 16 | Write byte enables |
| req_data_par | input | 16 | Data lane parity bits |
| log_clear | input | 1 | Write-one-to-clear of the log valid bit |
| log_valid | output | 1 | Error record held |
| log_is_data | output | 1 | 1 = data error record, 0 = address error record |
| log_addr | output | 36 | Captured address |
| log_addr_mask | output | 5 | Failing address lanes |
| log_data_mask | output | 16 | Failing data lanes |
| irq | output | 1 | Level interrupt |
| gen_addr | input | 36 | Inbound address to protect |
| gen_data | input | 128 | Inbound data to protect |
| gen_be | input | 16 | Inbound byte enables |
| gen_addr_par | output | 5 | Generated address parity |
| gen_data_par | output | 16 | Generated data parity |

## Verification
The bench builds the block with its default parameters: a 36-bit address, 128-bit data and 8-bit lanes. Because 36 is not a multiple of 8, these values bring the four-bit partial top address lane within reach, next to sixteen full data lanes whose parity includes the byte enable. The vectors flip chosen parity bits and byte enables so that single lanes, the partial lane, mixed address and data failures, and data failures on requests without data are each exercised. Directed tests then cover the sticky record, a clear coinciding with a new failure, disabled checking and the interrupt enable.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  // Number of lanes needed to cover a bus, counting a partial top lane
  function automatic int lanes_for(input int bus_w, input int lane_w);
    return (bus_w + lane_w - 1) / lane_w;
  endfunction

  typedef enum logic {
    KIND_ADDR = 1'b0,
    KIND_DATA = 1'b1
  } err_kind_e;

endpackage

// File: rtl/bpg_rst_sync.sv
module bpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/bpg_lane_xor.sv
module bpg_lane_xor
  import bpg_pkg::*;
#(
  parameter int BUS_W  = 36,
  parameter int LANE_W = 8,
  localparam int LANES = lanes_for(BUS_W, LANE_W)
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [LANES-1:0] extra,
  output logic [LANES-1:0] lane_xor
);

  for (genvar li = 0; li < LANES; li++) begin : g_lane
    localparam int LO = li * LANE_W;
    localparam int HI = ((li + 1) * LANE_W > BUS_W) ? BUS_W - 1 : (li + 1) * LANE_W - 1;
    assign lane_xor[li] = (^bus[HI:LO]) ^ extra[li];
  end

endmodule

// File: rtl/bpg_err_log.sv
module bpg_err_log
  import bpg_pkg::*;
#(
  parameter int ADDR_W  = 36,
  parameter int A_LANES = 5,
  parameter int D_LANES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [A_LANES-1:0] addr_fail,
  input  logic [D_LANES-1:0] data_fail,
  input  logic               clear,
  output logic               valid_o,
  output logic               is_data_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [A_LANES-1:0] amask_o,
  output logic [D_LANES-1:0] dmask_o
);

  logic               valid_q, valid_d;
  err_kind_e          kind_q, kind_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [A_LANES-1:0] amask_q, amask_d;
  logic [D_LANES-1:0] dmask_q, dmask_d;
  logic               any_fail;
  logic               capture;
  logic               load_en;

  assign any_fail = (|addr_fail) | (|data_fail);
  // A clear in the same cycle frees the slot for the new record
  assign capture  = any_fail & (~valid_q | clear);
  assign load_en  = capture | clear;

  always_comb begin
    valid_d = valid_q;
    kind_d  = kind_q;
    addr_d  = addr_q;
    amask_d = amask_q;
    dmask_d = dmask_q;
    if (capture) begin
      valid_d = 1'b1;
      kind_d  = (|addr_fail) ? KIND_ADDR : KIND_DATA;
      addr_d  = addr;
      amask_d = addr_fail;
      dmask_d = data_fail;
    end else if (clear) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      kind_q  <= KIND_ADDR;
      addr_q  <= '0;
      amask_q <= '0;
      dmask_q <= '0;
    end else if (load_en) begin
      valid_q <= valid_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      amask_q <= amask_d;
      dmask_q <= dmask_d;
    end
  end

  assign valid_o   = valid_q;
  assign is_data_o = (kind_q == KIND_DATA);
  assign addr_o    = addr_q;
  assign amask_o   = amask_q;
  assign dmask_o   = dmask_q;

endmodule

// File: rtl/bus_parity_guard.sv
module bus_parity_guard
  import bpg_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 128,
  parameter int LANE_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  chk_en,
  input  logic                                  irq_en,
  input  logic                                  req_valid,
  input  logic [ADDR_W-1:0]                     req_addr,
  input  logic [lanes_for(ADDR_W, LANE_W)-1:0]  req_addr_par,
  input  logic                                  req_has_data,
  input  logic [DATA_W-1:0]                     req_data,
  input  logic [lanes_for(DATA_W, LANE_W)-1:0]  req_be,
  input  logic [lanes_for(DATA_W, LANE_W)-1:0]  req_data_par,
  input  logic                                  log_clear,
  output logic                                  log_valid,
  output logic                                  log_is_data,
  output logic [ADDR_W-1:0]                     log_addr,
  output logic [lanes_for(ADDR_W, LANE_W)-1:0]  log_addr_mask,
  output logic [lanes_for(DATA_W, LANE_W)-1:0]  log_data_mask,
  output logic                                  irq,
  input  logic [ADDR_W-1:0]                     gen_addr,
  input  logic [DATA_W-1:0]                     gen_data,
  input  logic [lanes_for(DATA_W, LANE_W)-1:0]  gen_be,
  output logic [lanes_for(ADDR_W, LANE_W)-1:0]  gen_addr_par,
  output logic [lanes_for(DATA_W, LANE_W)-1:0]  gen_data_par
);

  localparam int A_LANES = lanes_for(ADDR_W, LANE_W);
  localparam int D_LANES = lanes_for(DATA_W, LANE_W);

  logic               rst_int_n;
  logic [A_LANES-1:0] chk_addr_xor;
  logic [D_LANES-1:0] chk_data_xor;
  logic [A_LANES-1:0] addr_fail;
  logic [D_LANES-1:0] data_fail;
  logic               addr_gate;
  logic               data_gate;

  bpg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Outbound check: a lane XOR of its covered bits and its parity bit must be zero
  bpg_lane_xor #(.BUS_W(ADDR_W), .LANE_W(LANE_W)) u_chk_addr (
    .bus      (req_addr),
    .extra    (req_addr_par),
    .lane_xor (chk_addr_xor)
  );

  bpg_lane_xor #(.BUS_W(DATA_W), .LANE_W(LANE_W)) u_chk_data (
    .bus      (req_data),
    .extra    (req_data_par ^ req_be),
    .lane_xor (chk_data_xor)
  );

  assign addr_gate = req_valid & chk_en;
  assign data_gate = req_valid & chk_en & req_has_data;
  assign addr_fail = addr_gate ? chk_addr_xor : '0;
  assign data_fail = data_gate ? chk_data_xor : '0;

  bpg_err_log #(
    .ADDR_W  (ADDR_W),
    .A_LANES (A_LANES),
    .D_LANES (D_LANES)
  ) u_log (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .addr      (req_addr),
    .addr_fail (addr_fail),
    .data_fail (data_fail),
    .clear     (log_clear),
    .valid_o   (log_valid),
    .is_data_o (log_is_data),
    .addr_o    (log_addr),
    .amask_o   (log_addr_mask),
    .dmask_o   (log_data_mask)
  );

  assign irq = log_valid & irq_en;

  // Inbound generation runs regardless of chk_en
  bpg_lane_xor #(.BUS_W(ADDR_W), .LANE_W(LANE_W)) u_gen_addr (
    .bus      (gen_addr),
    .extra    ('0),
    .lane_xor (gen_addr_par)
  );

  bpg_lane_xor #(.BUS_W(DATA_W), .LANE_W(LANE_W)) u_gen_data (
    .bus      (gen_data),
    .extra    (gen_be),
    .lane_xor (gen_data_par)
  );

endmodule

// File: rtl/bus_parity_guard_chk.sv
module bus_parity_guard_chk #(
  parameter int ADDR_W  = 36,
  parameter int A_LANES = 5,
  parameter int D_LANES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               chk_en,
  input logic               irq_en,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               log_clear,
  input logic               log_valid,
  input logic               log_is_data,
  input logic [ADDR_W-1:0]  log_addr,
  input logic [A_LANES-1:0] log_addr_mask,
  input logic [D_LANES-1:0] log_data_mask,
  input logic               irq
);

  // R4: no request, no new record
  a_r4_idle_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!log_valid && !req_valid) |=> !log_valid);

  // R5: checking disabled, no new record
  a_r5_disabled_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!log_valid && !chk_en) |=> !log_valid);

  // R6: captured address is that of the sampled request
  a_r6_capture_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(log_valid) |-> (log_addr == $past(req_addr)));

  // R6: a held record always names at least one failing lane
  a_r6_record_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> ((|log_addr_mask) || (|log_data_mask)));

  // R6: a data-type record has no address lane failure
  a_r6_kind_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && log_is_data) |-> (log_addr_mask == '0));

  // R7: held record is frozen without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !log_clear) |=> (log_valid && $stable(log_addr)
      && $stable(log_addr_mask) && $stable(log_data_mask) && $stable(log_is_data)));

  // R8: clear with no request empties the log
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && log_clear && !req_valid) |=> !log_valid);

  // R9: interrupt only with a held record and the enable set
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (log_valid && irq_en));

endmodule

bind bus_parity_guard bus_parity_guard_chk #(
  .ADDR_W  (ADDR_W),
  .A_LANES (A_LANES),
  .D_LANES (D_LANES)
) u_bpg_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .chk_en        (chk_en),
  .irq_en        (irq_en),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .log_clear     (log_clear),
  .log_valid     (log_valid),
  .log_is_data   (log_is_data),
  .log_addr      (log_addr),
  .log_addr_mask (log_addr_mask),
  .log_data_mask (log_data_mask),
  .irq           (irq)
);

// File: tb/test_bus_parity_guard.sv
module test_bus_parity_guard;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic         rst_n;
  logic         chk_en, irq_en, req_valid, req_has_data, log_clear;
  logic [35:0]  req_addr, gen_addr, log_addr;
  logic [4:0]   req_addr_par, log_addr_mask, gen_addr_par;
  logic [127:0] req_data, gen_data;
  logic [15:0]  req_be, req_data_par, log_data_mask, gen_be, gen_data_par;
  logic         log_valid, log_is_data, irq;

  bus_parity_guard i_bus_parity_guard (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .irq_en(irq_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_addr_par(req_addr_par),
    .req_has_data(req_has_data), .req_data(req_data), .req_be(req_be),
    .req_data_par(req_data_par), .log_clear(log_clear),
    .log_valid(log_valid), .log_is_data(log_is_data), .log_addr(log_addr),
    .log_addr_mask(log_addr_mask), .log_data_mask(log_data_mask), .irq(irq),
    .gen_addr(gen_addr), .gen_data(gen_data), .gen_be(gen_be),
    .gen_addr_par(gen_addr_par), .gen_data_par(gen_data_par)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench parity model: lane i covers bits [8i+7:8i] limited to the bus width
  function automatic logic [4:0] model_apar(input logic [35:0] a);
    logic [4:0] p = '0;
    for (int i = 0; i < 36; i++) p[i/8] ^= a[i];
    return p;
  endfunction

  function automatic logic [15:0] model_dpar(input logic [127:0] d, input logic [15:0] be);
    logic [15:0] p = be;
    for (int i = 0; i < 128; i++) p[i/8] ^= d[i];
    return p;
  endfunction

  typedef struct packed {
    logic [35:0] addr;
    logic [31:0] seed;
    logic [15:0] be;
    logic [4:0]  aflip;
    logic [15:0] dflip;
    logic [15:0] beflip;
    logic        has_data;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{36'h0_1234_5678, 32'hDEADBEEF, 16'hFFFF, 5'b00000, 16'h0000, 16'h0000, 1'b1},
    '{36'hF_0000_0001, 32'hA5A50F0F, 16'h00F0, 5'b00001, 16'h0000, 16'h0000, 1'b1},
    '{36'h8_FFFF_FFFF, 32'h00000000, 16'h8001, 5'b10000, 16'h0000, 16'h0000, 1'b0},
    '{36'h0_0000_0040, 32'h12345678, 16'h5555, 5'b00000, 16'h8001, 16'h0000, 1'b1},
    '{36'h0_0000_0080, 32'h12345678, 16'h5555, 5'b00000, 16'hFFFF, 16'h0000, 1'b0},
    '{36'h3_3333_3333, 32'hCAFEF00D, 16'h0F0F, 5'b00110, 16'h0100, 16'h0000, 1'b1},
    '{36'h7_FFFF_FF00, 32'h0BADC0DE, 16'hAAAA, 5'b00000, 16'h0000, 16'h0000, 1'b1},
    '{36'h1_0000_0000, 32'h55AA55AA, 16'h0000, 5'b00000, 16'h0000, 16'h0400, 1'b1},
    '{36'h2_4000_0000, 32'hFFFFFFFF, 16'hFFFF, 5'b01000, 16'h0000, 16'h0000, 1'b1}
  };

  // Drive one request cycle at a falling edge; it is sampled at the next rising edge
  task automatic send(input logic [35:0] a, input logic [4:0] aflip,
                      input logic [127:0] d, input logic [15:0] be,
                      input logic [15:0] dflip, input logic [15:0] beflip,
                      input logic hd, input logic clr);
    @(negedge clk);
    req_valid    = 1'b1;
    req_addr     = a;
    req_addr_par = model_apar(a) ^ aflip;
    req_data     = d;
    req_data_par = model_dpar(d, be) ^ dflip;
    req_be       = be ^ beflip;
    req_has_data = hd;
    log_clear    = clr;
    @(negedge clk);
    req_valid    = 1'b0;
    log_clear    = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    log_clear = 1'b1;
    @(negedge clk);
    log_clear = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; chk_en = 1'b1; irq_en = 1'b1; req_valid = 1'b0;
    req_addr = '0; req_addr_par = '0; req_has_data = 1'b0; req_data = '0;
    req_be = '0; req_data_par = '0; log_clear = 1'b0;
    gen_addr = '0; gen_data = '0; gen_be = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 log_valid", 64'(log_valid), 64'd0);
    check("R11 irq", 64'(irq), 64'd0);
    check("R11 masks", 64'({log_addr_mask, log_data_mask}), 64'd0);
    check("R11 addr", 64'({log_is_data, log_addr}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table: R1, R2, R3, R6
    for (int v = 0; v < NVEC; v++) begin
      vec_t t = VECS[v];
      logic [15:0] exp_d = t.has_data ? (t.dflip ^ t.beflip) : 16'h0;
      logic exp_v = (|t.aflip) | (|exp_d);
      send(t.addr, t.aflip, {4{t.seed}}, t.be, t.dflip, t.beflip, t.has_data, 1'b0);
      check($sformatf("R1/R2 vec%0d addr mask", v), 64'(log_addr_mask), exp_v ? 64'(t.aflip) : 64'(log_addr_mask));
      check($sformatf("R6 vec%0d valid", v), 64'(log_valid), 64'(exp_v));
      if (exp_v) begin
        check($sformatf("R3 vec%0d data mask", v), 64'(log_data_mask), 64'(exp_d));
        check($sformatf("R6 vec%0d addr", v), 64'(log_addr), 64'(t.addr));
        check($sformatf("R6 vec%0d kind", v), 64'(log_is_data), 64'((t.aflip == 0) && (exp_d != 0)));
        check($sformatf("R9 vec%0d irq", v), 64'(irq), 64'd1);
      end
      pulse_clear();
      check($sformatf("R8 vec%0d cleared", v), 64'(log_valid), 64'd0);
    end

    // R4: bad parity without the request strobe
    @(negedge clk);
    req_addr = 36'h0_0000_00FF; req_addr_par = 5'b11111; req_has_data = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R4 no strobe no capture", 64'(log_valid), 64'd0);

    // R5 / R10: checking off; generator still works
    chk_en = 1'b0;
    gen_addr = 36'hA_5A5A_F00F; gen_data = {4{32'h8421_1248}}; gen_be = 16'hC3A5;
    send(36'h1_2345_6789, 5'b11111, {4{32'h01020304}}, 16'hFFFF, 16'hFFFF, 16'h0, 1'b1, 1'b0);
    check("R5 disabled no capture", 64'(log_valid), 64'd0);
    check("R10 gen addr par", 64'(gen_addr_par), 64'(model_apar(gen_addr)));
    check("R10 gen data par", 64'(gen_data_par), 64'(model_dpar(gen_data, gen_be)));
    chk_en = 1'b1;

    // R7: sticky first record
    send(36'h0_0000_1111, 5'b00010, '0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0);
    send(36'h0_0000_2222, 5'b00100, '0, 16'h0, 16'h0001, 16'h0, 1'b1, 1'b0);
    check("R7 sticky addr", 64'(log_addr), 64'h1111);
    check("R7 sticky mask", 64'({log_addr_mask, log_data_mask}), 64'({5'b00010, 16'h0}));

    // R9: interrupt follows the enable
    @(negedge clk); irq_en = 1'b0;
    #1 check("R9 irq masked", 64'(irq), 64'd0);
    @(negedge clk); irq_en = 1'b1;
    #1 check("R9 irq re-enabled", 64'(irq), 64'd1);

    // R8: clear coinciding with a new failure captures the new one
    send(36'h0_0000_3333, 5'b00000, {4{32'h77777777}}, 16'h00FF, 16'h0020, 16'h0, 1'b1, 1'b1);
    check("R8 clear+new valid", 64'(log_valid), 64'd1);
    check("R8 clear+new addr", 64'(log_addr), 64'h3333);
    check("R8 clear+new data mask", 64'(log_data_mask), 64'h0020);
    check("R8 clear+new kind", 64'(log_is_data), 64'd1);
    pulse_clear();
    check("R8 clear alone", 64'(log_valid), 64'd0);
    check("R9 irq after clear", 64'(irq), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule